// File: doc/BRIEF.md
# Legacy Prefix Scanner for the SIMD Compare Opcode

This block sits in an instruction front end and looks at a byte stream, one byte per clock, under a valid/ready handshake. It takes in any run of legacy prefix bytes. It then takes the two-byte escape and the opcode byte. At that point it reports a header: which SIMD flavour of the compare opcode was selected, plus the segment override, the address-size and operand-size flags and the number of prefixes. The two bytes after the compare opcode (ModRM, then the immediate) are passed straight through, each tagged with its position.

The repeat prefixes take priority over the operand-size prefix, whatever order the bytes arrive in. When both repeat prefixes are present, the later one decides. Segment and address-size prefixes never affect the flavour. Any opcode other than the compare is reported with a single "other" flag, and scanning then starts afresh.

A prefix run that reaches the length limit puts the block in a blocking error state. A synchronous flush clears that state, and it also clears everything else.

Top module: `pfx_resolver`

## Requirements
- R1: After reset, `in_ready` is 1 and `hdr_valid`, `out_valid` and `too_long` are 0.
- R2: With no repeat prefix, `0F C2` gives `hdr_variant` 00 (packed single). If byte 66h is also present, it gives 01 (packed double). `hdr_cmp` is 1 in both cases.
- R3: F3h selects 10 (scalar single) and F2h selects 11 (scalar double). Once either of them is in the run, 66h has no effect on the flavour, whether 66h comes before or after it.
- R4: When F2h and F3h are both present, the last one in byte order decides the flavour. Repeating a byte changes nothing.
- R5: Bytes 67h, 26h, 2Eh, 36h, 3Eh, 64h and 65h never change the flavour. `hdr_seg` reports the last segment byte seen, coded ES=1, CS=2, SS=3, DS=4, FS=5, GS=6 and none=0.
- R6: `hdr_valid` is high for exactly one cycle: the cycle after the opcode byte is accepted. In that cycle `hdr_osz` shows whether 66h was seen, `hdr_asz` shows whether 67h was seen, and `hdr_cnt` holds the number of prefix bytes.
- R7: After a compare opcode, the next accepted byte appears one cycle later on `out_byte` with `out_valid`=1 and `out_pos`=0. The byte after that appears with `out_pos`=1.
- R8: A non-prefix byte other than 0Fh, or a byte other than C2h after 0Fh, raises `hdr_valid` with `hdr_other`=1 and `hdr_cmp`=0, and produces no pass-through output.
- R9: Accepting the 15th prefix byte of one instruction raises `too_long` on the next cycle. From then on `in_ready` stays 0 and no byte is taken until a flush. A run of 14 prefixes still decodes normally.
- R10: `flush` clears all state on the next edge, and it wins over a byte accepted in the same cycle.
- R11: Prefix state never carries over from one instruction to the next, whether the previous instruction ended on its immediate or on an "other" opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of all decode state |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Block can take a byte |
| hdr_valid | output | 1 | One-cycle header strobe after the opcode |
| hdr_variant | output | 2 | 00 PS, 01 PD, 10 SS, 11 SD |
| hdr_cmp | output | 1 | Opcode was the compare |
| hdr_other | output | 1 | Opcode was something else |
| hdr_seg | output | 3 | Last segment override code |
| hdr_asz | output | 1 | Address-size prefix seen |
| hdr_osz | output | 1 | Operand-size prefix seen |
| hdr_cnt | output | 4 | Number of prefix bytes |
| out_valid | output | 1 | Pass-through byte strobe |
| out_byte | output | 8 | Pass-through byte |
| out_pos | output | 1 | 0 = ModRM, 1 = immediate |
| too_long | output | 1 | Prefix run hit the length limit |

## Verification
Two functions can land on the same edge: a flush, and the acceptance of a byte that would otherwise move the decoder forward. The bench raises `flush` together with a valid 0Fh escape byte, part-way through a prefix run that holds both 66h and F3h. It then feeds C2h on its own. If flush won, the escape was dropped and the prefixes were cleared, so the C2h must show up as an "other" opcode with a prefix count of zero. The main sweep runs every prefix string of up to four bytes, drawn from the seven prefix kinds, back to back. This checks that the ordering rules and the state clearing hold across neighbouring instructions.

// File: rtl/pfxdec_pkg.sv
package pfxdec_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      VAR_PS = 2'b00,
      VAR_PD = 2'b01,
      VAR_SS = 2'b10,
      VAR_SD = 2'b11
   } simd_var_t;

   typedef enum logic [2:0] {
      SEG_NONE = 3'd0,
      SEG_ES   = 3'd1,
      SEG_CS   = 3'd2,
      SEG_SS   = 3'd3,
      SEG_DS   = 3'd4,
      SEG_FS   = 3'd5,
      SEG_GS   = 3'd6
   } seg_t;

   typedef struct packed {
      logic pfx;
      logic osz;
      logic asz;
      logic rep_f2;
      logic rep_f3;
      seg_t seg;
   } byte_class_t;

   function automatic byte_class_t classify(input logic [BYTE_W-1:0] b);
      byte_class_t c;
      c = '0;
      unique case (b)
         8'h66: begin c.pfx = 1'b1; c.osz = 1'b1; end
         8'h67: begin c.pfx = 1'b1; c.asz = 1'b1; end
         8'hF2: begin c.pfx = 1'b1; c.rep_f2 = 1'b1; end
         8'hF3: begin c.pfx = 1'b1; c.rep_f3 = 1'b1; end
         8'h26: begin c.pfx = 1'b1; c.seg = SEG_ES; end
         8'h2E: begin c.pfx = 1'b1; c.seg = SEG_CS; end
         8'h36: begin c.pfx = 1'b1; c.seg = SEG_SS; end
         8'h3E: begin c.pfx = 1'b1; c.seg = SEG_DS; end
         8'h64: begin c.pfx = 1'b1; c.seg = SEG_FS; end
         8'h65: begin c.pfx = 1'b1; c.seg = SEG_GS; end
         default: ;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/pfxdec_classify.sv
module pfxdec_classify
   import pfxdec_pkg::*;
(
   input  logic [BYTE_W-1:0] byte_i,
   output byte_class_t       cls_o
);
   always_comb cls_o = classify(byte_i);
endmodule

// File: rtl/pfxdec_accum.sv
module pfxdec_accum
   import pfxdec_pkg::*;
#(
   parameter int MAX_LEN       = 15,
   parameter bit REP_LAST_WINS = 1'b1,
   parameter int CNT_W         = $clog2(MAX_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             upd,
   input  byte_class_t      cls,
   output logic             rep_seen,
   output logic             rep_f2,
   output logic             osz,
   output logic             asz,
   output seg_t             seg,
   output logic [CNT_W-1:0] cnt,
   output logic             at_edge
);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_LEN);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_LEN - 1);

   logic is_rep;
   logic rep_steer;

   assign is_rep  = cls.rep_f2 | cls.rep_f3;
   assign at_edge = (cnt == CNT_LAST);

   generate
      if (REP_LAST_WINS) begin : g_rep_last
         assign rep_steer = is_rep;
      end else begin : g_rep_first
         assign rep_steer = is_rep & ~rep_seen;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rep_seen <= 1'b0;
         rep_f2   <= 1'b0;
         osz      <= 1'b0;
         asz      <= 1'b0;
         seg      <= SEG_NONE;
         cnt      <= '0;
      end else if (clr) begin
         rep_seen <= 1'b0;
         rep_f2   <= 1'b0;
         osz      <= 1'b0;
         asz      <= 1'b0;
         seg      <= SEG_NONE;
         cnt      <= '0;
      end else if (upd) begin
         if (is_rep)            rep_seen <= 1'b1;
         if (rep_steer)         rep_f2   <= cls.rep_f2;
         if (cls.osz)           osz      <= 1'b1;
         if (cls.asz)           asz      <= 1'b1;
         if (cls.seg != SEG_NONE) seg    <= cls.seg;
         if (cnt != CNT_MAX)    cnt      <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pfx_resolver.sv
module pfx_resolver
   import pfxdec_pkg::*;
#(
   parameter int          MAX_LEN       = 15,
   parameter bit          REP_LAST_WINS = 1'b1,
   parameter logic [7:0]  ESC_BYTE      = 8'h0F,
   parameter logic [7:0]  CMP_BYTE      = 8'hC2,
   parameter int          CNT_W         = $clog2(MAX_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   output logic             in_ready,
   output logic             hdr_valid,
   output logic [1:0]       hdr_variant,
   output logic             hdr_cmp,
   output logic             hdr_other,
   output logic [2:0]       hdr_seg,
   output logic             hdr_asz,
   output logic             hdr_osz,
   output logic [CNT_W-1:0] hdr_cnt,
   output logic             out_valid,
   output logic [7:0]       out_byte,
   output logic             out_pos,
   output logic             too_long
);
   if (MAX_LEN < 2) begin : g_bad_len
      $error("pfx_resolver: MAX_LEN must be at least 2");
   end
   if ((1 << CNT_W) <= MAX_LEN) begin : g_bad_cnt
      $error("pfx_resolver: CNT_W too narrow for MAX_LEN");
   end

   typedef enum logic [2:0] {ST_PFX, ST_ESC, ST_MODRM, ST_IMM, ST_ERR} st_t;

   st_t              state, nxt;
   byte_class_t      cls;
   logic             take, upd, clr, ld_hdr, ld_cmp, emit;
   logic             a_rep, a_f2, a_osz, a_asz, a_edge;
   seg_t             a_seg;
   logic [CNT_W-1:0] a_cnt;
   simd_var_t        var_now;

   pfxdec_classify i_cls (.byte_i(in_byte), .cls_o(cls));

   pfxdec_accum #(.MAX_LEN(MAX_LEN), .REP_LAST_WINS(REP_LAST_WINS), .CNT_W(CNT_W)) i_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .cls(cls),
      .rep_seen(a_rep), .rep_f2(a_f2), .osz(a_osz), .asz(a_asz),
      .seg(a_seg), .cnt(a_cnt), .at_edge(a_edge)
   );

   assign in_ready = (state != ST_ERR);
   assign too_long = (state == ST_ERR);
   assign take     = in_valid & in_ready & ~flush;
   assign var_now  = a_rep ? (a_f2 ? VAR_SD : VAR_SS) : (a_osz ? VAR_PD : VAR_PS);

   always_comb begin
      nxt    = state;
      upd    = 1'b0;
      clr    = flush;
      ld_hdr = 1'b0;
      ld_cmp = 1'b0;
      emit   = 1'b0;
      if (take) begin
         unique case (state)
            ST_PFX: begin
               if (cls.pfx) begin
                  upd = 1'b1;
                  if (a_edge) nxt = ST_ERR;
               end else if (in_byte == ESC_BYTE) begin
                  nxt = ST_ESC;
               end else begin
                  ld_hdr = 1'b1;
                  clr    = 1'b1;
               end
            end
            ST_ESC: begin
               ld_hdr = 1'b1;
               if (in_byte == CMP_BYTE) begin
                  ld_cmp = 1'b1;
                  nxt    = ST_MODRM;
               end else begin
                  clr = 1'b1;
                  nxt = ST_PFX;
               end
            end
            ST_MODRM: begin
               emit = 1'b1;
               nxt  = ST_IMM;
            end
            ST_IMM: begin
               emit = 1'b1;
               clr  = 1'b1;
               nxt  = ST_PFX;
            end
            default: ;
         endcase
      end
      if (flush) nxt = ST_PFX;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_PFX;
         hdr_valid   <= 1'b0;
         hdr_variant <= VAR_PS;
         hdr_cmp     <= 1'b0;
         hdr_other   <= 1'b0;
         hdr_seg     <= SEG_NONE;
         hdr_asz     <= 1'b0;
         hdr_osz     <= 1'b0;
         hdr_cnt     <= '0;
         out_valid   <= 1'b0;
         out_byte    <= '0;
         out_pos     <= 1'b0;
      end else begin
         state     <= nxt;
         hdr_valid <= ld_hdr;
         out_valid <= emit;
         if (ld_hdr) begin
            hdr_variant <= var_now;
            hdr_cmp     <= ld_cmp;
            hdr_other   <= ~ld_cmp;
            hdr_seg     <= a_seg;
            hdr_asz     <= a_asz;
            hdr_osz     <= a_osz;
            hdr_cnt     <= a_cnt;
         end
         if (emit) begin
            out_byte <= in_byte;
            out_pos  <= (state == ST_IMM);
         end
      end
   end
endmodule

// File: rtl/pfx_resolver_chk.sv
module pfx_resolver_chk #(
   parameter int MAX_LEN = 15,
   parameter int CNT_W   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             in_ready,
   input logic             hdr_valid,
   input logic [1:0]       hdr_variant,
   input logic             hdr_cmp,
   input logic             hdr_other,
   input logic             hdr_osz,
   input logic [CNT_W-1:0] hdr_cnt,
   input logic             out_valid,
   input logic             too_long
);
   // R9
   err_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      too_long |-> !in_ready);

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (too_long && !flush) |=> too_long);

   // R10
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!too_long && !hdr_valid && !out_valid));

   // R8
   hdr_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> ($countones({hdr_cmp, hdr_other}) == 1));

   // R2
   pd_needs_osz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && hdr_cmp && hdr_variant == 2'b01) |-> hdr_osz);

   // R2
   ps_without_osz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && hdr_cmp && hdr_variant == 2'b00) |-> !hdr_osz);

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> (int'(hdr_cnt) < MAX_LEN));

   // R7
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_valid && out_valid));
endmodule

bind pfx_resolver pfx_resolver_chk #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .in_ready(in_ready),
   .hdr_valid(hdr_valid), .hdr_variant(hdr_variant), .hdr_cmp(hdr_cmp),
   .hdr_other(hdr_other), .hdr_osz(hdr_osz), .hdr_cnt(hdr_cnt),
   .out_valid(out_valid), .too_long(too_long)
);

// File: tb/test_pfx_resolver.sv
module test_pfx_resolver;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       flush = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       in_ready, hdr_valid, hdr_cmp, hdr_other, hdr_asz, hdr_osz;
   logic [1:0] hdr_variant;
   logic [2:0] hdr_seg;
   logic [3:0] hdr_cnt;
   logic       out_valid, out_pos, too_long;
   logic [7:0] out_byte;

   int nchk = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   pfx_resolver i_pfx_resolver (
      .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_byte(in_byte),
      .in_ready(in_ready), .hdr_valid(hdr_valid), .hdr_variant(hdr_variant),
      .hdr_cmp(hdr_cmp), .hdr_other(hdr_other), .hdr_seg(hdr_seg), .hdr_asz(hdr_asz),
      .hdr_osz(hdr_osz), .hdr_cnt(hdr_cnt), .out_valid(out_valid), .out_byte(out_byte),
      .out_pos(out_pos), .too_long(too_long)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   function automatic logic [7:0] sym(input int k);
      case (k)
         0: return 8'h66;
         1: return 8'h67;
         2: return 8'hF2;
         3: return 8'hF3;
         4: return 8'h26;
         5: return 8'h2E;
         default: return 8'h36;
      endcase
   endfunction

   function automatic logic [2:0] seg_code(input logic [7:0] b);
      case (b)
         8'h26: return 3'd1;
         8'h2E: return 3'd2;
         8'h36: return 3'd3;
         8'h3E: return 3'd4;
         8'h64: return 3'd5;
         8'h65: return 3'd6;
         default: return 3'd0;
      endcase
   endfunction

   task automatic run_cmp(input logic [7:0] pf [16], input int n, input logic [7:0] imm);
      logic rep = 1'b0, f2 = 1'b0, osz = 1'b0, asz = 1'b0;
      logic [2:0] sg = 3'd0;
      logic [1:0] v;
      for (int i = 0; i < n; i++) begin
         if (pf[i] == 8'h66) osz = 1'b1;
         if (pf[i] == 8'h67) asz = 1'b1;
         if (pf[i] == 8'hF2) begin rep = 1'b1; f2 = 1'b1; end
         if (pf[i] == 8'hF3) begin rep = 1'b1; f2 = 1'b0; end
         if (seg_code(pf[i]) != 3'd0) sg = seg_code(pf[i]);
         put(pf[i]);
      end
      v = rep ? {1'b1, f2} : {1'b0, osz};
      put(8'h0F);
      put(8'hC2);
      chk("R6 hdr_valid", hdr_valid, 1);
      chk("R2/R3/R4 variant", hdr_variant, v);
      chk("R2 hdr_cmp", hdr_cmp, 1);
      chk("R5 hdr_seg", hdr_seg, sg);
      chk("R6 asz/osz/cnt", {hdr_asz, hdr_osz, hdr_cnt}, {asz, osz, 4'(n)});
      put(8'hC1);
      chk("R7 modrm", {hdr_valid, out_valid, out_pos, out_byte}, {3'b010, 8'hC1});
      put(imm);
      chk("R7 imm", {out_valid, out_pos, out_byte}, {2'b11, imm});
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      logic [7:0] pf [16];
      int total, code;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset", {in_ready, hdr_valid, out_valid, too_long}, 4'b1000);
      rst_n = 1'b1;

      // R2 R3 R4 R5 R6 R7 R11: every prefix string of length 0..4, back to back
      total = 1;
      for (int len = 0; len <= 4; len++) begin
         for (int c = 0; c < total; c++) begin
            code = c;
            for (int i = 0; i < len; i++) begin
               pf[i] = sym(code % 7);
               code  = code / 7;
            end
            run_cmp(pf, len, 8'(c));
         end
         total = total * 7;
      end

      // R5 remaining segment codes
      pf[0] = 8'h3E; pf[1] = 8'h64; pf[2] = 8'hF3; pf[3] = 8'h65;
      run_cmp(pf, 4, 8'h5A);
      pf[0] = 8'h64; pf[1] = 8'h66; pf[2] = 8'h3E;
      run_cmp(pf, 3, 8'hA5);

      // R8 plain one-byte opcode, then R11 no carry-over
      put(8'h66); put(8'hF2); put(8'h90);
      chk("R8 other one-byte", {hdr_valid, hdr_other, hdr_cmp, out_valid}, 4'b1100);
      put(8'h0F); put(8'hC2);
      chk("R11 cleared after other", {hdr_variant, hdr_osz, hdr_cnt}, 7'd0);
      put(8'hC1); put(8'h00);
      put(8'h0F); put(8'h10);
      chk("R8 other two-byte", {hdr_valid, hdr_other, hdr_cmp}, 3'b110);
      put(8'hC1);
      chk("R8 no passthrough", {out_valid, hdr_other, hdr_valid}, 3'b011);

      // R9 boundary: 14 prefixes still decode
      for (int i = 0; i < 14; i++) pf[i] = 8'h26;
      run_cmp(pf, 14, 8'h33);
      chk("R9 14 ok", too_long, 0);

      // R9 15 prefixes: error, input blocked
      for (int i = 0; i < 14; i++) put(8'h2E);
      chk("R9 not yet", too_long, 0);
      put(8'h2E);
      chk("R9 too_long", {too_long, in_ready}, 2'b10);
      put(8'h0F); put(8'hC2);
      chk("R9 blocked", {hdr_valid, too_long, in_ready}, 3'b010);

      // R10 flush clears error
      @(negedge clk); flush = 1'b1;
      @(posedge clk); #1; flush = 1'b0;
      chk("R10 flush clears err", {too_long, in_ready}, 2'b01);

      // R10 flush wins over a byte taken the same cycle
      put(8'h66); put(8'hF3);
      @(negedge clk); flush = 1'b1; in_valid = 1'b1; in_byte = 8'h0F;
      @(posedge clk); #1; flush = 1'b0; in_valid = 1'b0;
      chk("R10 no hdr on flush", {hdr_valid, out_valid}, 2'b00);
      put(8'hC2);
      chk("R10 escape dropped", {hdr_valid, hdr_other, hdr_cnt}, 6'b110000);
      put(8'h0F); put(8'hC2);
      chk("R10 state cleared", {hdr_variant, hdr_osz, hdr_cnt}, 7'd0);
      put(8'hC1); put(8'h01);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule